// File: doc/BRIEF.md
# Time-Sliced Shared RAM Read Demultiplexer

This block serves several read requesters through one synchronous RAM read port by giving each requester one clock slot in a repeating pixel period. A phase counter walks through the slots. In each slot an address multiplexer forwards that slot's requester address through a registered select chain to a dual-port RAM, whose read latency is a parameter. Bytes returning from the RAM enter a byte-wide shift pipe. Once per pixel, all slot results belonging to the same pixel are copied together from fixed taps of that pipe into one wide output register.

The tap for each slot is worked out during elaboration from the cycles per pixel, the select-chain latency and the RAM latency. Raising either latency moves every tap together, and the parallel result stays aligned without any hand tuning. The write port of the RAM is exposed as plain pins, so the surrounding logic can load content. The result leaves as a stream that has a valid strobe and no ready. The consumer has no back-pressure: it must take every strobe in the cycle it appears, and the register then holds the word until the next strobe.

Top module: `tdm_read_demux`

## Requirements
- R1: The phase counter counts 0,1,...,SLOTS-1 and wraps to 0. The address of requester k (`req_addr` bits k*ADDR_W+ADDR_W-1 down to k*ADDR_W) is read in phase k. The byte for requester k appears at `out_data` bits k*DATA_W+DATA_W-1 down to k*DATA_W.
- R2: On each strobe, every byte k of `out_data` equals the RAM content at the address that requester k drove during phase k of one and the same pixel.
- R3: Once running, `out_valid` is a single-cycle pulse with exactly SLOTS cycles between pulses. It is high only in the cycle in which the phase counter reads 1.
- R4: Count the first clock edge after reset release as edge 0, and let Q = ceil((SLOTS+MUX_LAT+RAM_LAT)/SLOTS). The first `out_valid` is visible right after edge SLOTS*Q, which is edge 10 with the defaults. There is no strobe before it.
- R5: Between strobes, `out_data` holds its last value.
- R6: A synchronous reset (`rst` high) clears `out_valid` and `out_data` to zero and restarts the phase and fill counting.
- R7: R2 and R4 hold for MUX_LAT from 1 to 4 and for RAM_LAT from 1 to 3, with no other change to the block.
- R8: A requester address is sampled only in its own phase. Changes in other phases have no effect on the result.
- R9: A write (`wr_en` high) stores `wr_data` at `wr_addr` on the clock edge. Reads issued after that edge return the new byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_addr | input | SLOTS*ADDR_W | Packed requester addresses, lane k at k*ADDR_W |
| wr_en | input | 1 | RAM write enable |
| wr_addr | input | ADDR_W | RAM write address |
| wr_data | input | DATA_W | RAM write byte |
| out_valid | output | 1 | One-cycle strobe marking a new parallel result (no ready) |
| out_data | output | SLOTS*DATA_W | Parallel per-pixel result, slot k at k*DATA_W |

## Verification
A wrong tap position or a miscounted latency shows at the ports as bytes taken from a neighbouring slot or a neighbouring pixel. This appears at the first strobe, SLOTS*Q edges after reset. A phase counter that slips or wraps early shows as a strobe arriving at the wrong spacing, and the result is visible within one pixel period. A fill counter that is wrong shows as a strobe that comes too early or too late after reset. Five differently parameterised instances run against the same stimulus, so an alignment error that appears only at the larger latencies is also exposed at the ports.

// File: rtl/tdm_rd_pkg.sv
`timescale 1ns/1ps
package tdm_rd_pkg;
  // Whole pixel periods between a pixel's phase 0 and the phase-0 edge that
  // captures its results.
  function automatic int unsigned lead_pixels(input int unsigned slots,
                                              input int unsigned mux_lat,
                                              input int unsigned ram_lat);
    return (slots + mux_lat + ram_lat + slots - 1) / slots;
  endfunction

  // Pipe index that holds slot k at the capture edge.
  function automatic int unsigned tap_pos(input int unsigned slots,
                                          input int unsigned mux_lat,
                                          input int unsigned ram_lat,
                                          input int unsigned k);
    return slots * lead_pixels(slots, mux_lat, ram_lat) - k - mux_lat - ram_lat - 1;
  endfunction
endpackage

// File: rtl/tdm_phase_ctr.sv
`timescale 1ns/1ps
module tdm_phase_ctr #(
  parameter int SLOTS = 5,
  parameter int LEAD  = 2,
  parameter int PH_W  = $clog2(SLOTS)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase,
  output logic            capture
);
  localparam int CNT_W = $clog2(LEAD + 1);
  localparam logic [PH_W-1:0]  LAST = PH_W'(SLOTS - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LEAD);

  logic [CNT_W-1:0] fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      fill  <= '0;
    end else begin
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
      if (phase == LAST && fill != FULL) fill <= fill + 1'b1;
    end
  end

  assign capture = (phase == '0) && (fill == FULL);

  // R1: counter steps by one inside a pixel
  a_r1_phase_step: assert property (@(posedge clk) disable iff (rst)
    (phase != LAST) |=> (phase == $past(phase) + 1'b1));
  // R1: counter wraps after the last slot
  a_r1_phase_wrap: assert property (@(posedge clk) disable iff (rst)
    (phase == LAST) |=> (phase == '0));
endmodule

// File: rtl/tdm_addr_mux.sv
`timescale 1ns/1ps
module tdm_addr_mux #(
  parameter int SLOTS   = 5,
  parameter int ADDR_W  = 8,
  parameter int MUX_LAT = 1,
  parameter int PH_W    = $clog2(SLOTS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SLOTS*ADDR_W-1:0] req_addr,
  input  logic [PH_W-1:0]         phase,
  output logic [ADDR_W-1:0]       rd_addr
);
  logic [ADDR_W-1:0] sel;
  logic [ADDR_W-1:0] stg [MUX_LAT];

  always_comb begin
    sel = '0;
    for (int k = 0; k < SLOTS; k++)
      if (phase == PH_W'(k)) sel = req_addr[k*ADDR_W +: ADDR_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MUX_LAT; i++) stg[i] <= '0;
    end else begin
      stg[0] <= sel;
      for (int i = 1; i < MUX_LAT; i++) stg[i] <= stg[i-1];
    end
  end

  assign rd_addr = stg[MUX_LAT-1];

  // R8: the first stage follows only the lane of the current phase
  a_r8_first_stage_lane: assert property (@(posedge clk) disable iff (rst)
    (phase == '0) |=> (stg[0] == $past(req_addr[ADDR_W-1:0])));
endmodule

// File: rtl/tdm_ram_model.sv
`timescale 1ns/1ps
module tdm_ram_model #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] q   [RD_LAT];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < RD_LAT; i++) q[i] <= '0;
    end else begin
      q[0] <= mem[rd_addr];
      for (int i = 1; i < RD_LAT; i++) q[i] <= q[i-1];
    end
  end

  assign rd_data = q[RD_LAT-1];
endmodule

// File: rtl/tdm_tap_pipe.sv
`timescale 1ns/1ps
module tdm_tap_pipe
  import tdm_rd_pkg::*;
#(
  parameter int SLOTS   = 5,
  parameter int DATA_W  = 8,
  parameter int MUX_LAT = 1,
  parameter int RAM_LAT = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DATA_W-1:0]       din,
  input  logic                    capture,
  output logic                    out_valid,
  output logic [SLOTS*DATA_W-1:0] out_data
);
  localparam int DEPTH = int'(tap_pos(SLOTS, MUX_LAT, RAM_LAT, 0)) + 1;

  logic [DATA_W-1:0]       pipe [DEPTH];
  logic [SLOTS*DATA_W-1:0] tapped;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_tap
    localparam int TAP = int'(tap_pos(SLOTS, MUX_LAT, RAM_LAT, k));
    assign tapped[k*DATA_W +: DATA_W] = pipe[TAP];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= capture;
      if (capture) out_data <= tapped;
    end
  end

  // R3: strobe lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  // R5: result holds between strobes
  a_r5_hold_between: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(out_data));
  // R6: reset clears the output
  a_r6_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));
endmodule

// File: rtl/tdm_read_demux.sv
`timescale 1ns/1ps
module tdm_read_demux
  import tdm_rd_pkg::*;
#(
  parameter int SLOTS   = 5,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int MUX_LAT = 1,
  parameter int RAM_LAT = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SLOTS*ADDR_W-1:0] req_addr,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  output logic                    out_valid,
  output logic [SLOTS*DATA_W-1:0] out_data
);
  localparam int PH_W = $clog2(SLOTS);
  localparam int LEAD = int'(lead_pixels(SLOTS, MUX_LAT, RAM_LAT));

  logic [PH_W-1:0]   phase;
  logic              capture;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  tdm_phase_ctr #(.SLOTS(SLOTS), .LEAD(LEAD), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst(rst), .phase(phase), .capture(capture));

  tdm_addr_mux #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .MUX_LAT(MUX_LAT), .PH_W(PH_W)) u_mux (
    .clk(clk), .rst(rst), .req_addr(req_addr), .phase(phase), .rd_addr(rd_addr));

  tdm_ram_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(RAM_LAT)) u_ram (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data));

  tdm_tap_pipe #(.SLOTS(SLOTS), .DATA_W(DATA_W), .MUX_LAT(MUX_LAT), .RAM_LAT(RAM_LAT)) u_pipe (
    .clk(clk), .rst(rst), .din(rd_data), .capture(capture),
    .out_valid(out_valid), .out_data(out_data));

  // R3: strobe lines up with phase 1 of the counter
  a_r3_valid_phase: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (phase == PH_W'(1)));
endmodule

// File: tb/tdm_read_demux_tb.sv
`timescale 1ns/1ps
module tdm_read_demux_tb_top;
  localparam int NCFG = 5;
  localparam int S    = 5;
  localparam int HMAX = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [39:0] req = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        ov [NCFG];
  logic [39:0] od [NCFG];

  always #2.5 clk = ~clk;

  tdm_read_demux dut_i (.clk(clk), .rst(rst), .req_addr(req), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_valid(ov[0]), .out_data(od[0]));
  tdm_read_demux #(.MUX_LAT(2)) dut_m2 (.clk(clk), .rst(rst), .req_addr(req), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_valid(ov[1]), .out_data(od[1]));
  tdm_read_demux #(.MUX_LAT(3)) dut_m3 (.clk(clk), .rst(rst), .req_addr(req), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_valid(ov[2]), .out_data(od[2]));
  tdm_read_demux #(.MUX_LAT(4)) dut_m4 (.clk(clk), .rst(rst), .req_addr(req), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_valid(ov[3]), .out_data(od[3]));
  tdm_read_demux #(.RAM_LAT(3)) dut_r3 (.clk(clk), .rst(rst), .req_addr(req), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_valid(ov[4]), .out_data(od[4]));

  int ml [NCFG] = '{1, 2, 3, 4, 1};
  int rl [NCFG] = '{2, 2, 2, 2, 3};

  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  int          n = 0;
  logic [7:0]  mem_m [256];
  logic [7:0]  hist [HMAX];
  logic        exp_v [NCFG];
  logic [39:0] exp_d [NCFG];
  bit          seen [NCFG];
  string       cur_tag = "R6";
  logic [15:0] lf = 16'hACE1;

  function automatic logic [7:0] pat(input logic [7:0] a, input logic [7:0] salt);
    return (a * 8'd29 + 8'd101 + salt) ^ {a[3:0], a[7:4]};
  endfunction

  // Reference model of the coming edge, then sampling at the next falling edge.
  task automatic tick();
    if (rst) begin
      n = 0;
      for (int c = 0; c < NCFG; c++) begin
        exp_v[c] = 1'b0; exp_d[c] = '0; seen[c] = 1'b0;
      end
    end else begin
      hist[n] = req[(n % S)*8 +: 8];
      for (int c = 0; c < NCFG; c++) begin
        int q;
        q = (S + ml[c] + rl[c] + S - 1) / S;
        if ((n % S) == 0 && n >= S*q) begin
          exp_v[c] = 1'b1;
          for (int k = 0; k < S; k++) exp_d[c][k*8 +: 8] = mem_m[hist[n - S*q + k]];
        end else begin
          exp_v[c] = 1'b0;
        end
      end
      n++;
    end
    if (wr_en) mem_m[wr_addr] = wr_data;
    @(negedge clk);
    for (int c = 0; c < NCFG; c++) begin
      string vt, dt;
      vt = rst ? "R6" : (exp_v[c] && !seen[c]) ? "R4" : "R3";
      dt = rst ? "R6" : (c != 0) ? "R7" : exp_v[c] ? cur_tag : "R5";
      checks++;
      if (ov[c] !== exp_v[c]) begin
        errors++;
        $display("FAIL %s cfg%0d valid at step %0d: got %b exp %b", vt, c, n, ov[c], exp_v[c]);
      end
      checks++;
      if (od[c] !== exp_d[c]) begin
        errors++;
        $display("FAIL %s cfg%0d data at step %0d: got %h exp %h", dt, c, n, od[c], exp_d[c]);
      end
      if (exp_v[c]) seen[c] = 1'b1;
    end
  endtask

  task automatic lanes_rand();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    for (int k = 0; k < S; k++) req[k*8 +: 8] = lf[7:0] ^ lf[15:8] ^ 8'(k * 53);
  endtask

  initial begin
    // R6: reset state, while loading the RAM (R9)
    @(negedge clk);
    for (int a = 0; a < 256; a++) begin
      wr_en = 1'b1; wr_addr = 8'(a); wr_data = pat(8'(a), 8'd0);
      tick();
    end
    wr_en = 1'b0;
    tick();

    // R1: each lane constant and distinct, byte order follows lane order
    rst = 1'b0;
    cur_tag = "R1";
    for (int k = 0; k < S; k++) req[k*8 +: 8] = 8'(10 + 17*k);
    repeat (40) tick();

    // R8: addresses change every cycle, only the own phase matters
    cur_tag = "R8";
    for (int i = 0; i < 400; i++) begin lanes_rand(); tick(); end

    // R2: all lanes on one address, then the extreme addresses
    cur_tag = "R2";
    req = {5{8'h5A}};
    repeat (30) tick();
    req = {8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF};
    repeat (30) tick();

    // R6 and R9: reset mid-run, rewrite part of the RAM, resume
    rst = 1'b1;
    cur_tag = "R6";
    tick();
    for (int a = 0; a < 32; a++) begin
      wr_en = 1'b1; wr_addr = 8'(a * 8); wr_data = pat(8'(a * 8), 8'h3C);
      tick();
    end
    wr_en = 1'b0;
    tick();
    rst = 1'b0;
    cur_tag = "R9";
    for (int i = 0; i < 300; i++) begin
      for (int k = 0; k < S; k++) req[k*8 +: 8] = 8'(((i + k) % 32) * 8);
      tick();
    end
    cur_tag = "R8";
    for (int i = 0; i < 200; i++) begin lanes_rand(); tick(); end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule